// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Encoder

This block turns one address byte and one command byte into a pulse-distance infrared remote-control frame on a single output pin. A one-cycle start strobe in the idle state captures both bytes and builds a 32-bit word. Bits 7:0 hold the address, bits 15:8 its bitwise inverse, bits 23:16 the command and bits 31:24 its bitwise inverse. The receiver can use the two inverted bytes to check the frame.

The frame is a long leader mark, then a long leader space. Each of the 32 word bits follows, least significant first, as a short fixed mark and then a space whose length gives the bit value. A closing short mark ends the last space. All timing counts in ticks of `TICK_DIV` clock cycles (0.125 ms at the nominal clock). The tick divider restarts when a frame is accepted, so every segment is an exact whole number of ticks. `busy` covers the whole frame, and `done` pulses once when the closing mark ends.

The sequencer has six states: IDLE, LEAD_MARK, LEAD_SPACE, BIT_MARK, BIT_SPACE and TAIL_MARK. Its transitions are:
- IDLE→LEAD_MARK on start.
- LEAD_MARK→LEAD_SPACE, LEAD_SPACE→BIT_MARK and BIT_MARK→BIT_SPACE, each when its segment runs out.
- BIT_SPACE→BIT_MARK when the segment runs out and bits remain.
- BIT_SPACE→TAIL_MARK when the segment of bit 31 runs out.
- TAIL_MARK→IDLE when the segment runs out.

Top module: `irpd_tx`

## Requirements
- R1: After reset: `busy` is 0, `done` is 0, and `ir_out` is at the idle level (0, or 1 when `ACTIVE_LOW`=1).
- R2: `start` is accepted only on a clock edge where the sequencer is idle, which includes the cycle in which `done` is high. A `start` during a frame has no effect: no extra frame is sent and the current frame is not changed.
- R3: The first mark begins in the cycle after the accepting edge. The leader mark lasts exactly 36 ticks and the leader space exactly 36 ticks. One tick is `TICK_DIV` clock cycles.
- R4: Every data bit opens with a mark of exactly 5 ticks.
- R5: After its mark, a 0 bit has a space of exactly 5 ticks and a 1 bit a space of exactly 13 ticks.
- R6: Bits are sent from index 0 to index 31. The word layout is: [7:0] address, [15:8] ~address, [23:16] command, [31:24] ~command.
- R7: After bit 31's space comes a 5-tick closing mark, and the output then returns to idle.
- R8: `busy` is high from the cycle after acceptance until the closing mark ends. `done` is high for exactly one cycle, the first cycle with `busy` low after a frame.
- R9: `ACTIVE_LOW`=1 inverts `ir_out` in every cycle; mark and space timing do not change.
- R10: Address and command are captured at acceptance. Changes on `addr` and `cmd` during a frame do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken only when idle |
| addr | input | FIELD_W | Address byte |
| cmd | input | FIELD_W | Command byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ir_out | output | 1 | Emitter drive (mark = 1 unless ACTIVE_LOW) |

## Verification
The bench targets five risks:
- **Tick phase at acceptance.** A divider that keeps running from idle would cut the leader mark short by a random part of a tick. The cycle-exact reference model catches this on the first frame.
- **Space selection.** Patterns of all zeros, all ones and mixed bits find a space that uses the wrong bit index or swaps the 5 and 13 tick lengths. The rebuilt word would then fail its complement relations or differ from the sent word.
- **Boundaries and re-triggering.** Holding `start` high across a frame end shows whether a design drops the back-to-back request in the `done` cycle. It also shows whether a design re-triggers in the middle of a frame.
- **Input capture.** Changing `addr` and `cmd` in the middle of a frame exposes a design that reads the ports live instead of latching them.
- **Closing mark.** A design that forgets the final mark leaves bit 31's space open and is caught.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_LEAD_MARK  = 3'd1,
        ST_LEAD_SPACE = 3'd2,
        ST_BIT_MARK   = 3'd3,
        ST_BIT_SPACE  = 3'd4,
        ST_TAIL_MARK  = 3'd5
    } irpd_state_t;

    function automatic logic irpd_is_mark(irpd_state_t s);
        return (s == ST_LEAD_MARK) || (s == ST_BIT_MARK) || (s == ST_TAIL_MARK);
    endfunction

endpackage

// File: rtl/irpd_tick.sv
module irpd_tick #(
    parameter int TICK_DIV = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/irpd_frame.sv
module irpd_frame #(
    parameter int FIELD_W = 8,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] addr,
    input  logic [FIELD_W-1:0] cmd,
    input  logic [IDX_W-1:0]   bit_idx,
    output logic               bit_val
);
    localparam int WORD_W = 4 * FIELD_W;

    logic [WORD_W-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= {~cmd, cmd, ~addr, addr};
        end
    end

    assign bit_val = word[bit_idx];
endmodule

// File: rtl/irpd_seq.sv
module irpd_seq
    import irpd_pkg::*;
#(
    parameter int LEAD_MARK_TICKS  = 36,
    parameter int LEAD_SPACE_TICKS = 36,
    parameter int BIT_MARK_TICKS   = 5,
    parameter int ZERO_SPACE_TICKS = 5,
    parameter int ONE_SPACE_TICKS  = 13,
    parameter int NBITS            = 32,
    parameter int IDX_W            = 5,
    parameter int SEG_W            = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             bit_val,
    output irpd_state_t      state,
    output logic [IDX_W-1:0] bit_idx,
    output logic             accept,
    output logic             done
);
    irpd_state_t      nxt;
    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] seg_len;
    logic             seg_last;
    logic             idx_last;

    always_comb begin
        unique case (state)
            ST_LEAD_MARK:  seg_len = SEG_W'(LEAD_MARK_TICKS);
            ST_LEAD_SPACE: seg_len = SEG_W'(LEAD_SPACE_TICKS);
            ST_BIT_MARK:   seg_len = SEG_W'(BIT_MARK_TICKS);
            ST_BIT_SPACE:  seg_len = bit_val ? SEG_W'(ONE_SPACE_TICKS) : SEG_W'(ZERO_SPACE_TICKS);
            ST_TAIL_MARK:  seg_len = SEG_W'(BIT_MARK_TICKS);
            default:       seg_len = SEG_W'(1);
        endcase
    end

    assign seg_last = tick && (seg == seg_len - SEG_W'(1));
    assign idx_last = (bit_idx == IDX_W'(NBITS - 1));
    assign accept   = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start)    nxt = ST_LEAD_MARK;
            ST_LEAD_MARK:  if (seg_last) nxt = ST_LEAD_SPACE;
            ST_LEAD_SPACE: if (seg_last) nxt = ST_BIT_MARK;
            ST_BIT_MARK:   if (seg_last) nxt = ST_BIT_SPACE;
            ST_BIT_SPACE:  if (seg_last) nxt = idx_last ? ST_TAIL_MARK : ST_BIT_MARK;
            ST_TAIL_MARK:  if (seg_last) nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    // state register with its segment and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            seg     <= '0;
            bit_idx <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                seg <= '0;
            end else if (tick && state != ST_IDLE) begin
                seg <= seg + SEG_W'(1);
            end
            if (accept) begin
                bit_idx <= '0;
            end else if (state == ST_BIT_SPACE && seg_last && !idx_last) begin
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state == ST_TAIL_MARK) && seg_last;
        end
    end
endmodule

// File: rtl/irpd_tx.sv
module irpd_tx
    import irpd_pkg::*;
#(
    parameter int TICK_DIV         = 6000,
    parameter int FIELD_W          = 8,
    parameter int LEAD_MARK_TICKS  = 36,
    parameter int LEAD_SPACE_TICKS = 36,
    parameter int BIT_MARK_TICKS   = 5,
    parameter int ZERO_SPACE_TICKS = 5,
    parameter int ONE_SPACE_TICKS  = 13,
    parameter bit ACTIVE_LOW       = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] addr,
    input  logic [FIELD_W-1:0] cmd,
    output logic               busy,
    output logic               done,
    output logic               ir_out
);
    localparam int NBITS = 4 * FIELD_W;
    localparam int IDX_W = $clog2(NBITS);
    localparam int MAX_A = (LEAD_MARK_TICKS > LEAD_SPACE_TICKS) ? LEAD_MARK_TICKS : LEAD_SPACE_TICKS;
    localparam int MAX_B = (BIT_MARK_TICKS > ZERO_SPACE_TICKS) ? BIT_MARK_TICKS : ZERO_SPACE_TICKS;
    localparam int MAX_C = (MAX_B > ONE_SPACE_TICKS) ? MAX_B : ONE_SPACE_TICKS;
    localparam int MAX_T = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int SEG_W = $clog2(MAX_T + 1);

    irpd_state_t      state;
    logic             tick;
    logic             accept;
    logic             bit_val;
    logic [IDX_W-1:0] bit_idx;
    logic             mark;

    irpd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    irpd_frame #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr    (addr),
        .cmd     (cmd),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    irpd_seq #(
        .LEAD_MARK_TICKS  (LEAD_MARK_TICKS),
        .LEAD_SPACE_TICKS (LEAD_SPACE_TICKS),
        .BIT_MARK_TICKS   (BIT_MARK_TICKS),
        .ZERO_SPACE_TICKS (ZERO_SPACE_TICKS),
        .ONE_SPACE_TICKS  (ONE_SPACE_TICKS),
        .NBITS            (NBITS),
        .IDX_W            (IDX_W),
        .SEG_W            (SEG_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .bit_val (bit_val),
        .state   (state),
        .bit_idx (bit_idx),
        .accept  (accept),
        .done    (done)
    );

    assign mark = irpd_is_mark(state);
    assign busy = (state != ST_IDLE);

    generate
        if (ACTIVE_LOW) begin : g_drive_low
            assign ir_out = ~mark;
        end else begin : g_drive_high
            assign ir_out = mark;
        end
    endgenerate
endmodule

// File: rtl/irpd_tx_chk.sv
module irpd_tx_chk #(
    parameter int TICK_DIV         = 6000,
    parameter int LEAD_MARK_TICKS  = 36,
    parameter int LEAD_SPACE_TICKS = 36,
    parameter int BIT_MARK_TICKS   = 5,
    parameter int ZERO_SPACE_TICKS = 5,
    parameter int ONE_SPACE_TICKS  = 13,
    parameter bit ACTIVE_LOW       = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ir_out
);
    logic mark_now;
    logic mark_prev;
    int   run;

    assign mark_now = ir_out ^ ACTIVE_LOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_prev <= 1'b0;
            run       <= 0;
        end else begin
            mark_prev <= mark_now;
            run       <= (mark_now != mark_prev) ? 1 : run + 1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mark_now); // R1
    AST_START_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mark_now); // R3
    AST_MARK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_prev && !mark_now) |->
            (run == LEAD_MARK_TICKS * TICK_DIV || run == BIT_MARK_TICKS * TICK_DIV)); // R4
    AST_SPACE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_prev && mark_now && $past(busy)) |->
            (run == LEAD_SPACE_TICKS * TICK_DIV || run == ZERO_SPACE_TICKS * TICK_DIV
             || run == ONE_SPACE_TICKS * TICK_DIV)); // R5
endmodule

bind irpd_tx irpd_tx_chk #(
    .TICK_DIV         (TICK_DIV),
    .LEAD_MARK_TICKS  (LEAD_MARK_TICKS),
    .LEAD_SPACE_TICKS (LEAD_SPACE_TICKS),
    .BIT_MARK_TICKS   (BIT_MARK_TICKS),
    .ZERO_SPACE_TICKS (ZERO_SPACE_TICKS),
    .ONE_SPACE_TICKS  (ONE_SPACE_TICKS),
    .ACTIVE_LOW       (ACTIVE_LOW)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .ir_out (ir_out)
);

// File: tb/test_irpd_tx.sv
module test_irpd_tx;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int LM = 36, LS = 36, BM = 5, S0 = 5, S1 = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] cmd = 8'h00;
    logic       busy, done, ir_out;
    logic       busy_n, done_n, ir_out_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    irpd_tx #(.TICK_DIV(TDIV)) i_irpd_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .cmd(cmd),
        .busy(busy), .done(done), .ir_out(ir_out));

    irpd_tx #(.TICK_DIV(TDIV), .ACTIVE_LOW(1'b1)) i_irpd_tx_inv (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .cmd(cmd),
        .busy(busy_n), .done(done_n), .ir_out(ir_out_n));

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: one queued level per expected clock cycle
    bit          q[$];
    logic [31:0] wq[$];
    bit          m_out = 1'b0, m_busy = 1'b0, m_done = 1'b0;
    int          accepts = 0;

    task automatic push_run(input bit lvl, input int ticks);
        repeat (ticks * TDIV) q.push_back(lvl);
    endtask

    always @(posedge clk) begin
        bit pb;
        if (rst_n) begin
            pb = m_busy;
            m_done = 1'b0;
            if (q.size() > 0) begin
                m_out = q.pop_front();
                m_busy = 1'b1;
            end else begin
                m_done = pb;
                m_busy = 1'b0;
                m_out = 1'b0;
                if (!pb && start) begin
                    logic [31:0] w;
                    w = {~cmd, cmd, ~addr, addr};
                    wq.push_back(w);
                    accepts++;
                    push_run(1'b1, LM);
                    push_run(1'b0, LS);
                    for (int i = 0; i < 32; i++) begin
                        push_run(1'b1, BM);
                        push_run(1'b0, w[i] ? S1 : S0);
                    end
                    push_run(1'b1, BM);
                    m_out = q.pop_front();
                    m_busy = 1'b1;
                end
            end
        end
    end

    // run-length decoder of the output pin
    bit          in_frame = 1'b0, lead_sp = 1'b0, prev_lvl = 1'b0;
    int          run = 0, nbits = 0, frames_seen = 0;
    logic [31:0] word = '0;

    task automatic on_run(input bit lvl, input int len);
        logic [31:0] ew;
        if (lvl) begin
            if (!in_frame) begin
                check(len == LM*TDIV, "R3", "leader mark cycles", len, LM*TDIV);
                in_frame = 1'b1; lead_sp = 1'b0; nbits = 0;
            end else if (nbits == 32) begin
                check(len == BM*TDIV, "R7", "closing mark cycles", len, BM*TDIV);
                check(done === 1'b1, "R7", "done at return to idle", done, 1);
                check(word[7:0] == ~word[15:8], "R6", "address complement", word[15:8], ~word[7:0]);
                check(word[23:16] == ~word[31:24], "R6", "command complement", word[31:24], ~word[23:16]);
                ew = (wq.size() > 0) ? wq.pop_front() : 32'hx;
                check(word === ew, "R10", "decoded word (R6 order)", word, ew);
                frames_seen++;
                in_frame = 1'b0;
            end else begin
                check(len == BM*TDIV, "R4", "bit mark cycles", len, BM*TDIV);
            end
        end else if (in_frame) begin
            if (!lead_sp) begin
                check(len == LS*TDIV, "R3", "leader space cycles", len, LS*TDIV);
                lead_sp = 1'b1;
            end else begin
                if (len == S1*TDIV) word[nbits] = 1'b1;
                else begin
                    check(len == S0*TDIV, "R5", "bit space cycles", len, S0*TDIV);
                    word[nbits] = 1'b0;
                end
                nbits++;
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(ir_out === m_out, "R3 R4 R5 R7", "ir_out level", ir_out, m_out);
            check(busy === m_busy, "R8", "busy", busy, m_busy);
            check(done === m_done, "R8", "done", done, m_done);
            check(ir_out_n === ~m_out, "R9", "inverted ir_out", ir_out_n, ~m_out);
            if (ir_out === prev_lvl) run++;
            else begin
                on_run(prev_lvl, run);
                prev_lvl = ir_out;
                run = 1;
            end
        end
    end

    task automatic send(input logic [7:0] a, input logic [7:0] c, input bit disturb);
        @(negedge clk);
        while (busy) @(negedge clk);
        addr = a; cmd = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (50) @(negedge clk);
            addr = ~a; cmd = c ^ 8'h5a; start = 1'b1;   // R2 R10
            repeat (3) @(negedge clk);
            start = 1'b0;
            repeat (700) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ir_out === 1'b0, "R1", "reset ir_out", ir_out, 0);
        check(ir_out_n === 1'b1, "R1", "reset inverted ir_out", ir_out_n, 1);
        check(busy === 1'b0, "R1", "reset busy", busy, 0);
        check(done === 1'b0, "R1", "reset done", done, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        send(8'h00, 8'h00, 1'b0);
        send(8'hFF, 8'hFF, 1'b0);
        send(8'hA5, 8'h3C, 1'b1);
        send(8'h01, 8'h80, 1'b0);
        // back-to-back request held high over a frame end (R2)
        @(negedge clk);
        addr = 8'h12; cmd = 8'hED; start = 1'b1;
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        addr = 8'h34; cmd = 8'h99;
        while (done !== 1'b1) @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        check(accepts == 6, "R2", "accepted frames", accepts, 6);
        check(frames_seen == accepts, "R2", "frames on pin", frames_seen, accepts);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
        summary();
    end
endmodule